// File: doc/BRIEF.md
# Processor Status Register Pair

This block keeps the two 16-bit status and control words of a small DSP-style CPU core. The core can write either word whole from the data bus, for example to restore machine state when a subroutine returns. It can read either word whole back onto the data bus to save that state. It can also set or clear single bits of either word. The block drives every field of both words to the rest of the core as a dedicated output. These fields are the auxiliary pointer and its buffer, the overflow flag and overflow mode, the interrupt mask, the data page pointer, the configuration bit, the test/control flag, the sign-extension mode, the carry, the external flag and the product shift mode.

The interrupt mask is protected against whole-word writes, so it can change only through single-bit operations or reset. Reserved positions hold no storage and always read as one. A synchronous reset loads fixed values into the flag fields. The pointer, page, overflow-mode and test/control fields keep their contents through reset.

The ALU reports carry, overflow and test/control results through three side ports. A whole-word write or a single-bit operation in the same cycle takes priority over them.

Top module: `cpu_status_pair`

## Requirements
- R1: When `op_sel[0]` (or `op_sel[1]`) is high and `rst` is low, word 0 (or word 1) takes the value of `wr_data` on the next clock edge. Reserved positions and the interrupt mask are not written.
- R2: A whole-word write leaves the interrupt mask (word 0, bit 9) unchanged. The word read on `rd_data` still shows the current value of that bit.
- R3: `rd_data` shows word 0 when `rd_reg` is 0 and word 1 when `rd_reg` is 1, in the same cycle. Reserved positions read as 1: word 0 bit 10; word 1 bits 8 to 5 and bits 3 to 2.
- R4: `op_sel[2]` sets bit `bit_idx` of the word chosen by `bit_reg`, and `op_sel[3]` clears it. The result is visible after the next clock edge.
- R5: When `op_sel[2]` and `op_sel[3]` are both high in one cycle, the addressed bit ends up 0.
- R6: A set or clear that addresses a reserved position has no effect. A set or clear addressed to a word that is written whole in the same cycle is dropped.
- R7: While `rst` is high, each clock edge loads these values: overflow flag 0, configuration bit 0, product shift mode 00, interrupt mask 1, sign-extension mode 1, carry 1, external flag 1.
- R8: A reset cycle leaves the auxiliary pointer, overflow mode, page pointer, auxiliary buffer and test/control flag unchanged. It also overrides every write, bit operation and side update given in that cycle.
- R9: An enabled side update loads `ovf_upd_val` into word 0 bit 12, `carry_upd_val` into word 1 bit 9, and `tflag_upd_val` into word 1 bit 11. A whole-word write of the same word in that cycle, or a set or clear of that bit, takes precedence.
- R10: The field outputs follow the bit layout. In word 0: 15..13 aux pointer, 12 overflow flag, 11 overflow mode, 9 interrupt mask, 8..0 page pointer. In word 1: 15..13 aux buffer, 12 configuration, 11 test/control, 10 sign-extension mode, 9 carry, 4 external flag, 1..0 product shift mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Requests: bit0 write word 0, bit1 write word 1, bit2 set bit, bit3 clear bit |
| bit_reg | input | 1 | Word addressed by a set or clear |
| bit_idx | input | 4 | Bit position addressed by a set or clear |
| wr_data | input | 16 | Data for whole-word writes |
| rd_reg | input | 1 | Word shown on rd_data |
| rd_data | output | 16 | Selected word, reserved positions as 1 |
| ovf_upd_en | input | 1 | Side update enable for overflow flag |
| ovf_upd_val | input | 1 | Side update value for overflow flag |
| carry_upd_en | input | 1 | Side update enable for carry |
| carry_upd_val | input | 1 | Side update value for carry |
| tflag_upd_en | input | 1 | Side update enable for test/control flag |
| tflag_upd_val | input | 1 | Side update value for test/control flag |
| aux_ptr | output | 3 | Auxiliary register pointer |
| ovf_flag | output | 1 | Overflow flag |
| ovf_mode | output | 1 | Overflow mode |
| irq_mask | output | 1 | Interrupt mask |
| page_ptr | output | 9 | Data page pointer |
| aux_buf | output | 3 | Auxiliary pointer buffer |
| cfg_bit | output | 1 | Configuration bit |
| test_flag | output | 1 | Test/control flag |
| sext_mode | output | 1 | Sign-extension mode |
| carry_flag | output | 1 | Carry |
| ext_flag | output | 1 | External flag |
| prod_shift | output | 2 | Product shift mode |

## Verification
The bench builds the block with its package defaults: a 16-bit word and a 4-bit bit index. With these, all sixteen positions of both words can be addressed by set and clear, reserved positions included. The words' bit layout, reset masks and write-protect mask are fixed by the package, so they are the ones the core uses. A per-bit model tracks which bits have a defined value, so the bits that reset leaves untouched are checked before any write and again across later resets. A random phase mixes writes, bit operations, side updates and occasional resets on top of the directed phases.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] stat_word_t;

    // request bit positions inside op_sel
    typedef enum int unsigned {
        OP_LD0 = 0,
        OP_LD1 = 1,
        OP_SET = 2,
        OP_CLR = 3
    } op_bit_e;

    // word 0 field positions
    localparam int W0_AUX_LO  = 13;
    localparam int W0_OVF     = 12;
    localparam int W0_OVM     = 11;
    localparam int W0_IRQ     = 9;
    localparam int W0_PAGE_LO = 0;
    localparam int PAGE_W     = 9;
    localparam int AUX_W      = 3;

    // word 1 field positions
    localparam int W1_BUF_LO  = 13;
    localparam int W1_CFG     = 12;
    localparam int W1_TFLAG   = 11;
    localparam int W1_SEXT    = 10;
    localparam int W1_CARRY   = 9;
    localparam int W1_EXT     = 4;
    localparam int W1_PS_LO   = 0;
    localparam int PS_W       = 2;

    // reserved, reset-to-one, reset-to-zero, write-protected masks
    localparam stat_word_t W0_RSVD     = stat_word_t'(1) << 10;
    localparam stat_word_t W0_RST_ONE  = stat_word_t'(1) << W0_IRQ;
    localparam stat_word_t W0_RST_ZERO = stat_word_t'(1) << W0_OVF;
    localparam stat_word_t W0_KEEP     = stat_word_t'(1) << W0_IRQ;

    localparam stat_word_t W1_RSVD     = (stat_word_t'(4'hF) << 5) | (stat_word_t'(2'h3) << 2);
    localparam stat_word_t W1_RST_ONE  = (stat_word_t'(1) << W1_SEXT) | (stat_word_t'(1) << W1_CARRY)
                                       | (stat_word_t'(1) << W1_EXT);
    localparam stat_word_t W1_RST_ZERO = (stat_word_t'(1) << W1_CFG) | (stat_word_t'(2'h3) << W1_PS_LO);
    localparam stat_word_t W1_KEEP     = '0;

endpackage

// File: rtl/stat_bitop.sv
module stat_bitop
    import stat_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = IDX_W,
    parameter logic [1:0][W-1:0] WRITABLE = '1
) (
    input  logic                do_set,
    input  logic                do_clr,
    input  logic                reg_sel,
    input  logic [IW-1:0]       idx,
    input  logic [1:0]          ld,
    output logic [1:0][W-1:0]   set_m,
    output logic [1:0][W-1:0]   clr_m
);

    for (genvar g = 0; g < 2; g++) begin : g_word
        logic         hit;
        logic [W-1:0] pos;

        always_comb begin
            hit = (reg_sel == 1'(g)) && !ld[g];
            pos = (W'(1) << idx) & WRITABLE[g];
            clr_m[g] = (do_clr && hit) ? pos : '0;
            // clear takes precedence over set on the same bit
            set_m[g] = (do_set && hit) ? (pos & ~clr_m[g]) : '0;
        end
    end

endmodule

// File: rtl/stat_word.sv
module stat_word #(
    parameter int           W        = 16,
    parameter logic [W-1:0] RSVD     = '0,
    parameter logic [W-1:0] RST_ONE  = '0,
    parameter logic [W-1:0] RST_ZERO = '0,
    parameter logic [W-1:0] LD_KEEP  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] side_en,
    input  logic [W-1:0] side_val,
    output logic [W-1:0] word_q
);

    localparam logic [W-1:0] HOLD = ~(RSVD | RST_ONE | RST_ZERO);

    logic [W-1:0] state_d;
    logic [W-1:0] state_q;

    always_comb begin
        state_d = state_q;
        // lowest priority: side updates from the datapath
        state_d = (state_d & ~side_en) | (side_val & side_en);
        // single-bit operations override side updates
        state_d = (state_d | set_mask) & ~clr_mask;
        // whole-word write overrides both, except protected bits
        if (ld) begin
            state_d = (wr_data & ~LD_KEEP) | (state_q & LD_KEEP);
        end
        // reset touches only its own fields
        if (rst) begin
            state_d = (state_q | RST_ONE) & ~RST_ZERO;
        end
        state_d = state_d | RSVD;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign word_q = state_q | RSVD;

    // R1: whole-word write lands next cycle
    a_r1_load_word: assert property (@(posedge clk) disable iff (rst)
        ld |=> ((word_q & ~RSVD & ~LD_KEEP) == ($past(wr_data) & ~RSVD & ~LD_KEEP)));

    // R2: protected bits survive a whole-word write
    a_r2_load_keeps_mask: assert property (@(posedge clk) disable iff (rst)
        ld |=> ((word_q & LD_KEEP) == $past(word_q & LD_KEEP)));

    // R5: a cleared bit reads zero afterwards even if set was requested
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (!ld && (clr_mask != '0)) |=> ((word_q & $past(clr_mask)) == '0));

    // R7: reset values of the reset-affected fields
    a_r7_reset_values: assert property (@(posedge clk)
        rst |=> (((word_q & RST_ONE) == RST_ONE) && ((word_q & RST_ZERO) == '0)));

    // R8: fields without reset term hold through reset
    a_r8_reset_holds: assert property (@(posedge clk)
        rst |=> ((word_q & HOLD) == $past(word_q & HOLD)));

endmodule

// File: rtl/cpu_status_pair.sv
module cpu_status_pair
    import stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           op_sel,
    input  logic                 bit_reg,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_reg,
    output logic [WORD_W-1:0]    rd_data,
    input  logic                 ovf_upd_en,
    input  logic                 ovf_upd_val,
    input  logic                 carry_upd_en,
    input  logic                 carry_upd_val,
    input  logic                 tflag_upd_en,
    input  logic                 tflag_upd_val,
    output logic [AUX_W-1:0]     aux_ptr,
    output logic                 ovf_flag,
    output logic                 ovf_mode,
    output logic                 irq_mask,
    output logic [PAGE_W-1:0]    page_ptr,
    output logic [AUX_W-1:0]     aux_buf,
    output logic                 cfg_bit,
    output logic                 test_flag,
    output logic                 sext_mode,
    output logic                 carry_flag,
    output logic                 ext_flag,
    output logic [PS_W-1:0]      prod_shift
);

    localparam logic [1:0][WORD_W-1:0] WRITABLE = {~W1_RSVD, ~W0_RSVD};

    logic [1:0][WORD_W-1:0] set_m;
    logic [1:0][WORD_W-1:0] clr_m;
    stat_word_t             side_en0, side_val0, side_en1, side_val1;
    stat_word_t             word0, word1;

    stat_bitop #(
        .W        (WORD_W),
        .IW       (IDX_W),
        .WRITABLE (WRITABLE)
    ) u_bitop (
        .do_set  (op_sel[OP_SET]),
        .do_clr  (op_sel[OP_CLR]),
        .reg_sel (bit_reg),
        .idx     (bit_idx),
        .ld      ({op_sel[OP_LD1], op_sel[OP_LD0]}),
        .set_m   (set_m),
        .clr_m   (clr_m)
    );

    always_comb begin
        side_en0  = stat_word_t'(ovf_upd_en)  << W0_OVF;
        side_val0 = stat_word_t'(ovf_upd_val) << W0_OVF;
        side_en1  = (stat_word_t'(carry_upd_en)  << W1_CARRY) | (stat_word_t'(tflag_upd_en)  << W1_TFLAG);
        side_val1 = (stat_word_t'(carry_upd_val) << W1_CARRY) | (stat_word_t'(tflag_upd_val) << W1_TFLAG);
    end

    stat_word #(
        .W        (WORD_W),
        .RSVD     (W0_RSVD),
        .RST_ONE  (W0_RST_ONE),
        .RST_ZERO (W0_RST_ZERO),
        .LD_KEEP  (W0_KEEP)
    ) u_word0 (
        .clk      (clk),
        .rst      (rst),
        .ld       (op_sel[OP_LD0]),
        .wr_data  (wr_data),
        .set_mask (set_m[0]),
        .clr_mask (clr_m[0]),
        .side_en  (side_en0),
        .side_val (side_val0),
        .word_q   (word0)
    );

    stat_word #(
        .W        (WORD_W),
        .RSVD     (W1_RSVD),
        .RST_ONE  (W1_RST_ONE),
        .RST_ZERO (W1_RST_ZERO),
        .LD_KEEP  (W1_KEEP)
    ) u_word1 (
        .clk      (clk),
        .rst      (rst),
        .ld       (op_sel[OP_LD1]),
        .wr_data  (wr_data),
        .set_mask (set_m[1]),
        .clr_mask (clr_m[1]),
        .side_en  (side_en1),
        .side_val (side_val1),
        .word_q   (word1)
    );

    assign rd_data    = rd_reg ? word1 : word0;

    assign aux_ptr    = word0[W0_AUX_LO +: AUX_W];
    assign ovf_flag   = word0[W0_OVF];
    assign ovf_mode   = word0[W0_OVM];
    assign irq_mask   = word0[W0_IRQ];
    assign page_ptr   = word0[W0_PAGE_LO +: PAGE_W];
    assign aux_buf    = word1[W1_BUF_LO +: AUX_W];
    assign cfg_bit    = word1[W1_CFG];
    assign test_flag  = word1[W1_TFLAG];
    assign sext_mode  = word1[W1_SEXT];
    assign carry_flag = word1[W1_CARRY];
    assign ext_flag   = word1[W1_EXT];
    assign prod_shift = word1[W1_PS_LO +: PS_W];

    // R9: side update of carry takes effect when nothing stronger targets it
    a_r9_side_carry: assert property (@(posedge clk) disable iff (rst)
        (carry_upd_en && !op_sel[OP_LD1]
         && !((op_sel[OP_SET] || op_sel[OP_CLR]) && bit_reg && (bit_idx == IDX_W'(W1_CARRY))))
        |=> (carry_flag == $past(carry_upd_val)));

    // R9: side update of overflow flag
    a_r9_side_ovf: assert property (@(posedge clk) disable iff (rst)
        (ovf_upd_en && !op_sel[OP_LD0]
         && !((op_sel[OP_SET] || op_sel[OP_CLR]) && !bit_reg && (bit_idx == IDX_W'(W0_OVF))))
        |=> (ovf_flag == $past(ovf_upd_val)));

endmodule

// File: tb/cpu_status_pair_bench.sv
module cpu_status_pair_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_sel;
    logic        bit_reg;
    logic [3:0]  bit_idx;
    logic [15:0] wr_data;
    logic        rd_reg;
    logic [15:0] rd_data;
    logic        ovf_upd_en, ovf_upd_val, carry_upd_en, carry_upd_val, tflag_upd_en, tflag_upd_val;
    logic [2:0]  aux_ptr, aux_buf;
    logic        ovf_flag, ovf_mode, irq_mask, cfg_bit, test_flag, sext_mode, carry_flag, ext_flag;
    logic [8:0]  page_ptr;
    logic [1:0]  prod_shift;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string tag = "R7";

    // model state: value and known-bit masks
    logic [15:0] m0, m1, k0, k1;
    localparam logic [15:0] RES0 = 16'h0400;
    localparam logic [15:0] RES1 = 16'h01EC;

    always #2.5 clk = ~clk;

    cpu_status_pair u_cpu_status_pair (
        .clk(clk), .rst(rst), .op_sel(op_sel), .bit_reg(bit_reg), .bit_idx(bit_idx),
        .wr_data(wr_data), .rd_reg(rd_reg), .rd_data(rd_data),
        .ovf_upd_en(ovf_upd_en), .ovf_upd_val(ovf_upd_val),
        .carry_upd_en(carry_upd_en), .carry_upd_val(carry_upd_val),
        .tflag_upd_en(tflag_upd_en), .tflag_upd_val(tflag_upd_val),
        .aux_ptr(aux_ptr), .ovf_flag(ovf_flag), .ovf_mode(ovf_mode), .irq_mask(irq_mask),
        .page_ptr(page_ptr), .aux_buf(aux_buf), .cfg_bit(cfg_bit), .test_flag(test_flag),
        .sext_mode(sext_mode), .carry_flag(carry_flag), .ext_flag(ext_flag), .prod_shift(prod_shift)
    );

    function automatic bit is_res(int r, int b);
        if (r == 0) return b == 10;
        return (b >= 5 && b <= 8) || b == 2 || b == 3;
    endfunction

    task automatic model_update();
        logic [15:0] n0 = m0;
        logic [15:0] n1 = m1;
        if (rst) begin
            n0[12] = 1'b0; n0[9] = 1'b1;
            n1[12] = 1'b0; n1[10] = 1'b1; n1[9] = 1'b1; n1[4] = 1'b1; n1[1] = 1'b0; n1[0] = 1'b0;
            k0 = k0 | 16'h1200;
            k1 = k1 | 16'h1613;
        end else begin
            if (op_sel[0]) begin
                for (int b = 0; b < 16; b++) if (b != 9) n0[b] = wr_data[b];
                k0 = k0 | 16'hFDFF;
            end else begin
                if (ovf_upd_en) begin n0[12] = ovf_upd_val; k0[12] = 1'b1; end
                if (bit_reg == 1'b0 && !is_res(0, int'(bit_idx))) begin
                    if (op_sel[2]) begin n0[bit_idx] = 1'b1; k0[bit_idx] = 1'b1; end
                    if (op_sel[3]) begin n0[bit_idx] = 1'b0; k0[bit_idx] = 1'b1; end
                end
            end
            if (op_sel[1]) begin
                n1 = wr_data;
                k1 = 16'hFFFF;
            end else begin
                if (carry_upd_en) begin n1[9] = carry_upd_val; k1[9] = 1'b1; end
                if (tflag_upd_en) begin n1[11] = tflag_upd_val; k1[11] = 1'b1; end
                if (bit_reg == 1'b1 && !is_res(1, int'(bit_idx))) begin
                    if (op_sel[2]) begin n1[bit_idx] = 1'b1; k1[bit_idx] = 1'b1; end
                    if (op_sel[3]) begin n1[bit_idx] = 1'b0; k1[bit_idx] = 1'b1; end
                end
            end
        end
        m0 = n0;
        m1 = n1;
    endtask

    task automatic check(string what, logic [15:0] act, logic [15:0] exp, logic [15:0] known);
        checks++;
        if ((act & known) !== (exp & known)) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (mask %h)", tag, what, act & known, exp & known, known);
        end
    endtask

    task automatic compare();
        logic [15:0] f0, f1, e0, e1;
        f0 = {aux_ptr, ovf_flag, ovf_mode, 1'b1, irq_mask, page_ptr};
        f1 = {aux_buf, cfg_bit, test_flag, sext_mode, carry_flag, 4'hF, ext_flag, 2'b11, prod_shift};
        e0 = m0 | RES0;
        e1 = m1 | RES1;
        check("fields0 R10", f0, e0, k0);
        check("fields1 R10", f1, e1, k1);
        check("rd_data R3", rd_data, rd_reg ? e1 : e0, rd_reg ? k1 : k0);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        rst = 0; op_sel = 0; bit_reg = 0; bit_idx = 0; wr_data = 0;
        ovf_upd_en = 0; ovf_upd_val = 0; carry_upd_en = 0; carry_upd_val = 0;
        tflag_upd_en = 0; tflag_upd_val = 0;
    endtask

    task automatic bitop(logic [3:0] op, logic r, int idx);
        idle(); op_sel = op; bit_reg = r; bit_idx = 4'(idx);
    endtask

    initial begin
        m0 = '0; m1 = '0; k0 = RES0; k1 = RES1;
        idle(); rd_reg = 0;
        @(negedge clk);
        // R7 reset values
        tag = "R7"; rst = 1; step(); rd_reg = 1; step();
        // R1 whole-word writes, R3 readback with reserved ones
        tag = "R1"; idle(); op_sel = 4'b0011; wr_data = 16'hFFFF; step();
        idle(); op_sel = 4'b0001; wr_data = 16'h0000; step(); rd_reg = 0; step();
        tag = "R3"; idle(); op_sel = 4'b0010; wr_data = 16'h0000; step(); rd_reg = 1; step();
        tag = "R1"; idle(); op_sel = 4'b0011; wr_data = 16'hA5C3; step(); rd_reg = 0; step();
        // R4 set and clear, including interrupt mask
        tag = "R4"; bitop(4'b1000, 0, 9); step();
        bitop(4'b0100, 1, 4); step(); bitop(4'b1000, 1, 0); step();
        bitop(4'b0100, 0, 3); step(); bitop(4'b0100, 1, 12); step();
        // R2 load keeps interrupt mask at 0, then at 1
        tag = "R2"; idle(); op_sel = 4'b0001; wr_data = 16'hFFFF; step();
        bitop(4'b0100, 0, 9); step();
        idle(); op_sel = 4'b0001; wr_data = 16'h0000; step();
        // R5 clear wins
        tag = "R5"; bitop(4'b0100, 1, 10); step(); bitop(4'b1100, 1, 10); step();
        bitop(4'b1100, 0, 11); step();
        // R6 reserved positions and same-cycle write drop bit ops
        tag = "R6"; rd_reg = 1; bitop(4'b1000, 1, 6); step(); bitop(4'b1000, 1, 2); step();
        rd_reg = 0; bitop(4'b1000, 0, 10); step();
        bitop(4'b0101, 0, 0); wr_data = 16'h0000; step();
        bitop(4'b1010, 1, 15); wr_data = 16'hFFFF; step();
        // R9 side ports and their priority
        tag = "R9"; idle(); ovf_upd_en = 1; ovf_upd_val = 1; carry_upd_en = 1; carry_upd_val = 0;
        tflag_upd_en = 1; tflag_upd_val = 0; step();
        idle(); carry_upd_en = 1; carry_upd_val = 1; op_sel = 4'b0010; wr_data = 16'h0000; step();
        bitop(4'b1000, 1, 11); tflag_upd_en = 1; tflag_upd_val = 1; step();
        bitop(4'b0100, 0, 12); ovf_upd_en = 1; ovf_upd_val = 0; step();
        // R8 reset holds untouched fields and overrides operations
        tag = "R8"; idle(); op_sel = 4'b0011; wr_data = 16'h6B5A; step();
        idle(); rst = 1; op_sel = 4'b0011; wr_data = 16'h1111; carry_upd_en = 1; step();
        idle(); rst = 1; bitop(4'b1000, 1, 10); rst = 1; step();
        // random mix
        tag = "R1 random";
        for (int i = 0; i < 400; i++) begin
            rst = ($urandom_range(0, 24) == 0);
            op_sel = 4'($urandom); bit_reg = 1'($urandom); bit_idx = 4'($urandom);
            wr_data = 16'($urandom); rd_reg = 1'($urandom);
            ovf_upd_en = 1'($urandom); ovf_upd_val = 1'($urandom);
            carry_upd_en = 1'($urandom); carry_upd_val = 1'($urandom);
            tflag_upd_en = 1'($urandom); tflag_upd_val = 1'($urandom);
            step();
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule